// File: doc/BRIEF.md
# BCD Decade Digit Counter

One decimal digit held in 8421 BCD. On each rising clock edge the digit does one of four things: it clears, it loads a preset nibble, it steps up by one, or it holds. Clearing has the highest priority, then loading, then stepping, then holding. The digit steps from 9 back to 0.

Two enables must both be high for the digit to step. The first, the parallel enable, is usually tied to a global run signal. The second, the trickle enable, also gates the carry output. The carry output is high only when the trickle enable is high and the digit reads 9. To build a multi-digit counter, feed each digit's carry into the trickle enable of the next digit. Every digit then steps on the same edge, and no digit's clock is derived from another.

A parameter chooses between two reset styles. With the asynchronous style, the active-low reset clears the digit at once, with no clock edge needed. With the synchronous style, it clears the digit at the next rising edge. The six codes above 9 are never produced by counting. If one of them is loaded, it is stored as loaded, and counting brings the digit back into 0..9 within two steps.

Top module: `bcd_digit_counter`

## Requirements
- R1: With `ld_n`=1, `run_en`=1, `chain_en`=1 and the digit in 0..8, each rising edge raises `digit` by one.
- R2: With the same enables and the digit at 9 (4'b1001), the next edge gives 0 (4'b0000).
- R3: With `ld_n`=1 and either `run_en` or `chain_en` low, `digit` keeps its value across the edge.
- R4: With `ld_n`=0 and reset inactive, the next edge copies `preset` into `digit` whatever the enables are. A code from 10 to 15 is stored unchanged.
- R5: A low `rst_n` clears `digit` to 0 ahead of any load or count. With `ASYNC_RST`=1 this happens at once, between edges. With `ASYNC_RST`=0 it happens at the next rising edge.
- R6: `carry` equals `chain_en` AND (`digit`==9). It follows `chain_en` with no clock edge and does not depend on `run_en`.
- R7: While counting is enabled, the codes above 9 step as follows: 10→11→6, 12→13→4 and 14→15→2. Every such code is back in 0..9 within two edges.
- R8: Changes on `ld_n`, `preset`, `run_en`, `chain_en` and, in the synchronous style, `rst_n` between edges leave `digit` unchanged until the next rising edge.
- R9: Three digits chained carry to trickle enable, with shared parallel enables, count 0..999 and wrap to 0. The chain advances exactly once per edge on which the global enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous by parameter |
| ld_n | input | 1 | Active-low preset load |
| run_en | input | 1 | Parallel count enable |
| chain_en | input | 1 | Trickle count enable; also gates `carry` |
| preset | input | 4 | Value loaded when `ld_n` is low |
| digit | output | 4 | Current BCD state |
| carry | output | 1 | High when `chain_en` is high and `digit` is 9 |

## Verification
Three collisions are exercised.

The first is a synchronous reset and a load on the same edge. Both are asserted together with a nonzero preset, and the edge must give 0.

The second is a load and a count on the same edge. A load is requested with both count enables high, and the preset value must win over the incremented value.

The third is an asynchronous clear in the middle of a clock period. It is dropped half a period before an edge, and the digit is sampled before that edge arrives. The digit must already be 0. At the same moment, the synchronous-style instance fed the same reset must still show its old value.

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter #(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_n,
  input  logic       run_en,
  input  logic       chain_en,
  input  logic [3:0] preset,
  output logic [3:0] digit,
  output logic       carry
);

  localparam logic [3:0] TOP = 4'd9;

  logic [3:0] state_q, state_d;
  logic       step;

  function automatic logic [3:0] succ(input logic [3:0] v);
    case (v)
      4'd9:    succ = 4'd0;
      4'd10:   succ = 4'd11;
      4'd11:   succ = 4'd6;
      4'd12:   succ = 4'd13;
      4'd13:   succ = 4'd4;
      4'd14:   succ = 4'd15;
      4'd15:   succ = 4'd2;
      default: succ = v + 4'd1;
    endcase
  endfunction

  assign step = ld_n & run_en & chain_en;

  always_comb begin
    if (!ld_n)     state_d = preset;
    else if (step) state_d = succ(state_q);
    else           state_d = state_q;
  end

  generate
    if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;

      // R5: asynchronous clear holds the digit at zero at every sampled edge
      p_async_clear_r5: assert property (@(posedge clk) !rst_n |-> digit == 4'd0);
    end else begin : g_srst
      always_ff @(posedge clk)
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;

      // R5: synchronous clear wins over load and count on the next edge
      p_sync_clear_r5: assert property (@(posedge clk) !rst_n |=> digit == 4'd0);
    end
  endgenerate

  assign digit = state_q;
  assign carry = chain_en & (state_q == TOP);

  p_increment_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && run_en && chain_en && digit < TOP) |=> digit == $past(digit) + 4'd1);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && run_en && chain_en && digit == TOP) |=> digit == 4'd0);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && !(run_en && chain_en)) |=> $stable(digit));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> digit == $past(preset));

  p_carry_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (chain_en && digit == TOP));

  p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && run_en && chain_en && digit > TOP && digit[0]) |=> digit <= TOP);

endmodule

// File: tb/test_bcd_digit_counter.sv
module test_bcd_digit_counter;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       rst_a, rst_s, ld_n, run_en, chain_en;
  logic [3:0] preset;
  logic [3:0] q_a, q_s;
  logic       c_a, c_s;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bcd_digit_counter #(.ASYNC_RST(1'b1)) i_bcd_digit_counter (
    .clk(clk), .rst_n(rst_a), .ld_n(ld_n), .run_en(run_en), .chain_en(chain_en),
    .preset(preset), .digit(q_a), .carry(c_a));

  bcd_digit_counter #(.ASYNC_RST(1'b0)) i_sync (
    .clk(clk), .rst_n(rst_s), .ld_n(ld_n), .run_en(run_en), .chain_en(chain_en),
    .preset(preset), .digit(q_s), .carry(c_s));

  logic       rst_c, g_en;
  logic [3:0] cq [3];
  logic       ctc [3];
  logic       trk [3];

  assign trk[0] = g_en;
  for (genvar i = 0; i < 3; i++) begin : g_chain
    if (i > 0) begin : g_link
      assign trk[i] = ctc[i-1];
    end
    bcd_digit_counter #(.ASYNC_RST(1'b1)) i_stage (
      .clk(clk), .rst_n(rst_c), .ld_n(1'b1), .run_en(g_en), .chain_en(trk[i]),
      .preset(4'd0), .digit(cq[i]), .carry(ctc[i]));
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(negedge clk);
  endtask

  task automatic set_in(input logic l, input logic p, input logic t, input logic [3:0] d);
    ld_n = l; run_en = p; chain_en = t; preset = d;
  endtask

  task automatic load_both(input logic [3:0] v);
    set_in(1'b0, 1'b0, 1'b0, v);
    edge1();
    set_in(1'b1, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_reset();
    rst_a = 1'b0; rst_s = 1'b0; set_in(1'b1, 1'b0, 1'b0, 4'd0);
    edge1(); edge1();
    chk("R5 reset async", q_a, 0);
    chk("R5 reset sync", q_s, 0);
    rst_a = 1'b1;
    set_in(1'b0, 1'b1, 1'b1, 4'd7);
    edge1();
    chk("R5 sync reset beats load", q_s, 0);
    chk("R4 load async inst", q_a, 7);
    rst_s = 1'b1;
    edge1();
    chk("R4 load sync inst", q_s, 7);
    set_in(1'b1, 1'b0, 1'b0, 4'd0);
    rst_a = 1'b0; rst_s = 1'b0;
    #1;
    chk("R5 async clear between edges", q_a, 0);
    chk("R5 sync waits for edge", q_s, 7);
    edge1();
    chk("R5 sync cleared at edge", q_s, 0);
    rst_a = 1'b1; rst_s = 1'b1;
    edge1();
  endtask

  task automatic t_count();
    int m = 0;
    load_both(4'd0);
    set_in(1'b1, 1'b1, 1'b1, 4'd0);
    for (int k = 0; k < 12; k++) begin
      edge1();
      m = (m + 1) % 10;
      chk(m == 0 ? "R2 wrap" : "R1 count", q_a, m);
      chk("R1 count sync inst", q_s, m);
    end
    set_in(1'b1, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_hold();
    load_both(4'd4);
    set_in(1'b1, 1'b0, 1'b1, 4'd0); edge1();
    chk("R3 hold run_en low", q_a, 4);
    set_in(1'b1, 1'b1, 1'b0, 4'd0); edge1();
    chk("R3 hold chain_en low", q_a, 4);
    set_in(1'b1, 1'b0, 1'b0, 4'd0); edge1();
    chk("R3 hold both low", q_s, 4);
  endtask

  task automatic t_load();
    load_both(4'd12);
    edge1();
    chk("R4 illegal code stored", q_a, 12);
    set_in(1'b0, 1'b1, 1'b1, 4'd3); edge1();
    chk("R4 load beats count", q_a, 3);
    set_in(1'b1, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_illegal();
    for (int c = 10; c < 16; c++) begin
      int e;
      case (c)
        10: e = 11; 11: e = 6; 12: e = 13;
        13: e = 4;  14: e = 15; default: e = 2;
      endcase
      load_both(4'(c));
      set_in(1'b1, 1'b1, 1'b1, 4'd0); edge1();
      chk("R7 unused code step", q_a, e);
      edge1();
      chk("R7 back in range", int'(q_a <= 4'd9), 1);
      set_in(1'b1, 1'b0, 1'b0, 4'd0);
    end
  endtask

  task automatic t_carry();
    load_both(4'd9);
    set_in(1'b1, 1'b0, 1'b1, 4'd0); #1;
    chk("R6 carry at nine", c_a, 1);
    chain_en = 1'b0; #1;
    chk("R6 carry follows chain_en", c_a, 0);
    chain_en = 1'b1; run_en = 1'b0; #1;
    chk("R6 carry ignores run_en", c_a, 1);
    load_both(4'd8);
    chain_en = 1'b1; #1;
    chk("R6 no carry at eight", c_a, 0);
    chain_en = 1'b0;
  endtask

  task automatic t_midcycle();
    load_both(4'd5);
    set_in(1'b0, 1'b1, 1'b1, 4'd2);
    #(CLK_P/2 - 1);
    chk("R8 load waits for edge", q_a, 5);
    set_in(1'b1, 1'b0, 1'b1, 4'd2);
    rst_s = 1'b0; #1;
    rst_s = 1'b1;
    @(negedge clk);
    chk("R8 late change used only at edge", q_a, 5);
    chk("R8 glitch on sync reset ignored", q_s, 5);
    set_in(1'b1, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_cascade();
    int m = 0;
    g_en = 1'b0; rst_c = 1'b0;
    edge1();
    rst_c = 1'b1;
    chk("R9 chain cleared", cq[2]*100 + cq[1]*10 + cq[0], 0);
    for (int k = 0; k < 1100; k++) begin
      g_en = (k % 7 != 3);
      edge1();
      if (g_en) m = (m + 1) % 1000;
      if (k % 50 == 0 || m == 0 || m == 999)
        chk("R9 chain value", cq[2]*100 + cq[1]*10 + cq[0], m);
    end
    g_en = 1'b0;
  endtask

  initial begin
    rst_c = 1'b0; g_en = 1'b0;
    t_reset();
    t_count();
    t_hold();
    t_load();
    t_illegal();
    t_carry();
    t_midcycle();
    t_cascade();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule